// File: doc/BRIEF.md
# SDRAM Power-Up Initialisation Sequencer

This block drives the command, address and control pins of an SDRAM from reset until the memory is ready for normal traffic. Once reset is released it keeps clock enable and the data mask high while it drives no-operation commands for a programmable settling period. It then precharges every bank, issues a programmable number of auto-refresh commands (never fewer than two), and loads the mode register. After a short quiet period it raises a done flag, which stays high until the next reset.

Each step is spaced by a programmable cycle count. The settling period, the precharge-to-refresh gap (row precharge time) and the refresh-to-refresh gap (row cycle time) are all inputs. The mode word is assembled from separate fields: burst length, burst order, read latency and write burst mode. A latency code that the memory does not accept is replaced by latency 3 before it is loaded, and a sticky error flag records that the substitution took place. A controller that sits after this block waits for done and then takes over the pins.

Top module: `sdram_boot_seq`

## Requirements
- R1: From reset until done, cke and dqm are 1, and every cycle that carries no command is a NOP ({cs_n,ras_n,cas_n,we_n} = 0111). From the cycle done rises onward, cke stays 1 and dqm is 0.
- R2: Take cycle 0 as the first clock period after the last edge at which rst is sampled high. The precharge-all command ({cs_n,ras_n,cas_n,we_n} = 0010, addr = 12'h400 with only bit 10 set) is driven once, in cycle max(wait_cycles,1). A new reset at any point restarts the sequence from cycle 0.
- R3: The first auto-refresh (0001) follows the precharge by max(trp_cycles,2) cycles.
- R4: Exactly max(refresh_count,2) auto-refreshes are issued, each following the one before by max(trc_cycles,2) cycles. The mode register set follows the last refresh by max(trc_cycles,2) cycles.
- R5: The mode register set (0000) is issued exactly once, with ba = 00, addr[11:10] = 00 and addr[8:7] = 00.
- R6: The mode register set carries addr[2:0] = burst_len, addr[3] = burst_interleave, addr[6:4] = the latency code and addr[9] = write_single.
- R7: Latency codes 010 and 011 are passed through unchanged. Any other code is sent as 011, and in that case lat_err rises in the cycle after the mode register set and holds until reset. lat_err is 0 after reset and is 0 whenever the code is legal.
- R8: The two cycles after the mode register set are NOPs. done rises 3 cycles after the mode register set and then stays 1, with only NOPs driven, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| wait_cycles | input | WAIT_W (16) | Length of the NOP settling period in cycles |
| trp_cycles | input | GAP_W (8) | Gap from precharge to the first refresh |
| trc_cycles | input | GAP_W (8) | Gap between refreshes and from the last refresh to the mode set |
| refresh_count | input | REF_W (4) | Number of auto-refreshes; values below 2 are raised to 2 |
| burst_len | input | 3 | Burst length code for addr[2:0] |
| burst_interleave | input | 1 | Burst order bit for addr[3] |
| cas_lat | input | 3 | Requested read latency code |
| write_single | input | 1 | Write burst mode bit for addr[9] |
| cke | output | 1 | Clock enable, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address, always 00 during the sequence |
| addr | output | 12 | Address bus: bit 10 for precharge-all, mode word for the mode set |
| dqm | output | 1 | Data mask, high until done |
| done | output | 1 | Sequence complete, sticky |
| lat_err | output | 1 | A reserved latency code was replaced, sticky |

## Verification
Two decisions land on the same cycle. In one cycle the row-cycle timer expires and the refresh counter shows whether any refreshes remain, and that cycle alone decides between one more refresh and the mode register set. The vectors provoke this with refresh counts of 0, 1 and 2 (all raised to 2), with 3, 8 and 15, and with minimum-length gaps. The bench judges each case by counting the refresh commands and by comparing the cycle of the mode register set with the value computed from the clamped counts. The second pairing is the latency substitution and the mode register set, which happen in the same cycle. Reserved codes 000, 101 and 111 are applied, and the bench checks both the latency field on the bus and that lat_err first appears one cycle later.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

    localparam int ADDR_W = 12;
    localparam int BA_W   = 2;
    localparam int AP_BIT = 10;
    localparam int MRD_GAP = 3;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_PRE,
        ST_TRP,
        ST_REF,
        ST_TRC,
        ST_MRS,
        ST_TMRD,
        ST_DONE
    } boot_st_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_NOP = sd_cmd_t'(4'b0111);
    localparam sd_cmd_t CMD_PRE = sd_cmd_t'(4'b0010);
    localparam sd_cmd_t CMD_REF = sd_cmd_t'(4'b0001);
    localparam sd_cmd_t CMD_MRS = sd_cmd_t'(4'b0000);

    typedef struct packed {
        logic [1:0] rsv_hi;
        logic       wr_single;
        logic [1:0] op_mode;
        logic [2:0] cas_lat;
        logic       interleave;
        logic [2:0] burst;
    } mode_word_t;

    localparam logic [2:0] LAT_FALLBACK = 3'b011;

    function automatic logic lat_legal(input logic [2:0] code);
        return (code == 3'b010) || (code == 3'b011);
    endfunction

endpackage

// File: rtl/sdram_boot_timer.sv
module sdram_boot_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (load)
            cnt <= load_val;
        else if (cnt > CNT_W'(1))
            cnt <= cnt - CNT_W'(1);
    end

    assign expired = (cnt <= CNT_W'(1));
endmodule

// File: rtl/sdram_boot_refcnt.sv
module sdram_boot_refcnt #(
    parameter int REF_W = 4
) (
    input  logic             clk,
    input  logic             load,
    input  logic [REF_W-1:0] load_val,
    input  logic             dec,
    output logic             empty
);
    logic [REF_W-1:0] left;

    always_ff @(posedge clk) begin
        if (load)
            left <= load_val;
        else if (dec && (left != '0))
            left <= left - REF_W'(1);
    end

    assign empty = (left == '0);
endmodule

// File: rtl/sdram_boot_mode.sv
module sdram_boot_mode
    import sdram_boot_pkg::*;
(
    input  logic [2:0]  burst_len,
    input  logic        burst_interleave,
    input  logic [2:0]  cas_lat,
    input  logic        write_single,
    output mode_word_t  word,
    output logic        lat_bad
);
    always_comb begin
        lat_bad         = !lat_legal(cas_lat);
        word.rsv_hi     = 2'b00;
        word.wr_single  = write_single;
        word.op_mode    = 2'b00;
        word.cas_lat    = lat_bad ? LAT_FALLBACK : cas_lat;
        word.interleave = burst_interleave;
        word.burst      = burst_len;
    end
endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
    import sdram_boot_pkg::*;
#(
    parameter int WAIT_W = 16,
    parameter int GAP_W  = 8,
    parameter int REF_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WAIT_W-1:0] wait_cycles,
    input  logic [GAP_W-1:0]  trp_cycles,
    input  logic [GAP_W-1:0]  trc_cycles,
    input  logic [REF_W-1:0]  refresh_count,
    input  logic [2:0]        burst_len,
    input  logic              burst_interleave,
    input  logic [2:0]        cas_lat,
    input  logic              write_single,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              dqm,
    output logic              done,
    output logic              lat_err
);
    localparam logic [REF_W-1:0] MIN_REFS = REF_W'(2);

    boot_st_t          state, state_nx;
    logic              tmr_load, tmr_exp;
    logic [WAIT_W-1:0] tmr_val;
    logic              refs_empty;
    logic [REF_W-1:0]  refs_load_val;
    mode_word_t        mword;
    logic              mlat_bad;
    sd_cmd_t           cmd;

    function automatic logic [WAIT_W-1:0] gap_load(input logic [GAP_W-1:0] n);
        return (n < GAP_W'(2)) ? WAIT_W'(1) : WAIT_W'(n - GAP_W'(1));
    endfunction

    sdram_boot_timer #(.CNT_W(WAIT_W)) u_timer (
        .clk      (clk),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    assign refs_load_val = (refresh_count < MIN_REFS) ? MIN_REFS : refresh_count;

    sdram_boot_refcnt #(.REF_W(REF_W)) u_refs (
        .clk      (clk),
        .load     (state == ST_PRE),
        .load_val (refs_load_val),
        .dec      (state == ST_REF),
        .empty    (refs_empty)
    );

    sdram_boot_mode u_mode (
        .burst_len        (burst_len),
        .burst_interleave (burst_interleave),
        .cas_lat          (cas_lat),
        .write_single     (write_single),
        .word             (mword),
        .lat_bad          (mlat_bad)
    );

    always_comb begin
        tmr_load = rst;
        tmr_val  = wait_cycles;
        if (!rst) begin
            unique case (state)
                ST_PRE: begin tmr_load = 1'b1; tmr_val = gap_load(trp_cycles); end
                ST_REF: begin tmr_load = 1'b1; tmr_val = gap_load(trc_cycles); end
                ST_MRS: begin tmr_load = 1'b1; tmr_val = WAIT_W'(MRD_GAP - 1); end
                default: ;
            endcase
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT: if (tmr_exp) state_nx = ST_PRE;
            ST_PRE:  state_nx = ST_TRP;
            ST_TRP:  if (tmr_exp) state_nx = ST_REF;
            ST_REF:  state_nx = ST_TRC;
            ST_TRC:  if (tmr_exp) state_nx = refs_empty ? ST_MRS : ST_REF;
            ST_MRS:  state_nx = ST_TMRD;
            ST_TMRD: if (tmr_exp) state_nx = ST_DONE;
            default: state_nx = ST_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_WAIT;
            lat_err <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_MRS && mlat_bad)
                lat_err <= 1'b1;
        end
    end

    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        unique case (state)
            ST_PRE: begin cmd = CMD_PRE; addr[AP_BIT] = 1'b1; end
            ST_REF: cmd = CMD_REF;
            ST_MRS: begin cmd = CMD_MRS; addr = mword; end
            default: ;
        endcase
    end

    assign cs_n  = cmd.cs_n;
    assign ras_n = cmd.ras_n;
    assign cas_n = cmd.cas_n;
    assign we_n  = cmd.we_n;
    assign ba    = '0;
    assign cke   = 1'b1;
    assign done  = (state == ST_DONE);
    assign dqm   = !done;
endmodule

// File: rtl/sdram_boot_chk.sv
module sdram_boot_chk (
    input logic        clk,
    input logic        rst,
    input logic        cke,
    input logic        cs_n,
    input logic        ras_n,
    input logic        cas_n,
    input logic        we_n,
    input logic [1:0]  ba,
    input logic [11:0] addr,
    input logic        dqm,
    input logic        done,
    input logic        lat_err
);
    logic [3:0] pins;
    logic       is_nop, is_pre, is_ref, is_mrs;
    logic       seen_pre, seen_ref, seen_mrs;
    logic [7:0] ref_n;

    assign pins   = {cs_n, ras_n, cas_n, we_n};
    assign is_nop = (pins == 4'b0111);
    assign is_pre = (pins == 4'b0010);
    assign is_ref = (pins == 4'b0001);
    assign is_mrs = (pins == 4'b0000);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_pre <= 1'b0;
            seen_ref <= 1'b0;
            seen_mrs <= 1'b0;
            ref_n    <= '0;
        end else begin
            seen_pre <= seen_pre | is_pre;
            seen_ref <= seen_ref | is_ref;
            seen_mrs <= seen_mrs | is_mrs;
            if (is_ref && ref_n != 8'hFF)
                ref_n <= ref_n + 8'd1;
        end
    end

    AST_INIT_PINS_HIGH: assert property (@(posedge clk) disable iff (rst)
        !done |-> (cke && dqm)); // R1

    AST_PRE_FIRST: assert property (@(posedge clk) disable iff (rst)
        is_pre |-> (!seen_pre && !seen_ref && !seen_mrs && addr == 12'h400)); // R2

    AST_REF_AFTER_PRE: assert property (@(posedge clk) disable iff (rst)
        is_ref |-> (seen_pre && !seen_mrs)); // R3

    AST_MRS_REF_COUNT: assert property (@(posedge clk) disable iff (rst)
        is_mrs |-> (ref_n >= 8'd2 && !seen_mrs)); // R4

    AST_MRS_ZERO_FIELDS: assert property (@(posedge clk) disable iff (rst)
        is_mrs |-> (ba == 2'b00 && addr[11:10] == 2'b00 && addr[8:7] == 2'b00)); // R5

    AST_MRS_LAT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        is_mrs |-> (addr[6:4] == 3'b010 || addr[6:4] == 3'b011)); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        lat_err |=> lat_err); // R7

    AST_MRS_QUIET_NEXT: assert property (@(posedge clk) disable iff (rst)
        is_mrs |=> (is_nop && !done)); // R8

    AST_MRS_QUIET_SECOND: assert property (@(posedge clk) disable iff (rst)
        $past(is_mrs, 2) |-> (is_nop && !done)); // R8

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        done |=> (done && is_nop && !dqm)); // R8

    AST_DONE_NEEDS_MRS: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> seen_mrs); // R8
endmodule

bind sdram_boot_seq sdram_boot_chk u_chk (.*);

// File: tb/sdram_boot_seq_test.sv
module sdram_boot_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] wait_cycles = '0;
    logic [7:0]  trp_cycles = '0;
    logic [7:0]  trc_cycles = '0;
    logic [3:0]  refresh_count = '0;
    logic [2:0]  burst_len = '0;
    logic        burst_interleave = 1'b0;
    logic [2:0]  cas_lat = 3'b010;
    logic        write_single = 1'b0;
    logic        cke, cs_n, ras_n, cas_n, we_n, dqm, done, lat_err;
    logic [1:0]  ba;
    logic [11:0] addr;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    sdram_boot_seq uut (
        .clk(clk), .rst(rst), .wait_cycles(wait_cycles), .trp_cycles(trp_cycles),
        .trc_cycles(trc_cycles), .refresh_count(refresh_count), .burst_len(burst_len),
        .burst_interleave(burst_interleave), .cas_lat(cas_lat), .write_single(write_single),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .dqm(dqm), .done(done), .lat_err(lat_err)
    );

    typedef struct packed {
        logic [15:0] w;
        logic [7:0]  trp;
        logic [7:0]  trc;
        logic [3:0]  refs;
        logic [2:0]  bl;
        logic        bt;
        logic [2:0]  cl;
        logic        ws;
        logic [11:0] exp_word;
        logic        exp_err;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{16'd20,  8'd3,  8'd7,  4'd2,  3'd3, 1'b0, 3'd2, 1'b0, 12'h023, 1'b0},
        '{16'd0,   8'd0,  8'd0,  4'd0,  3'd0, 1'b1, 3'd3, 1'b1, 12'h238, 1'b0},
        '{16'd1,   8'd1,  8'd1,  4'd1,  3'd7, 1'b1, 3'd5, 1'b0, 12'h03F, 1'b1},
        '{16'd50,  8'd2,  8'd2,  4'd8,  3'd2, 1'b0, 3'd0, 1'b1, 12'h232, 1'b1},
        '{16'd200, 8'd10, 8'd20, 4'd3,  3'd1, 1'b1, 3'd3, 1'b0, 12'h039, 1'b0},
        '{16'd5,   8'd4,  8'd3,  4'd15, 3'd3, 1'b0, 3'd7, 1'b1, 12'h233, 1'b1}
    };

    function automatic int at_least(input int v, input int m);
        return (v < m) ? m : v;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        wait_cycles      = v.w;
        trp_cycles       = v.trp;
        trc_cycles       = v.trc;
        refresh_count    = v.refs;
        burst_len        = v.bl;
        burst_interleave = v.bt;
        cas_lat          = v.cl;
        write_single     = v.ws;
    endtask

    task automatic run_vec(input vec_t v, input int limit, input bit do_check);
        int pre_at = -1, pre_addr = 0, pre_n = 0;
        int first_ref = -1, last_ref = -1, ref_n = 0, gap_bad = 0;
        int mrs_at = -1, mrs_addr = 0, mrs_ba = 0, mrs_n = 0;
        int done_at = -1, pin_bad = 0, early_err = 0;
        int p_exp, t_exp, c_exp, r_exp;
        logic [3:0] c;
        @(negedge clk);
        apply(v);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < limit; k++) begin
            c = {cs_n, ras_n, cas_n, we_n};
            if (mrs_at < 0 && lat_err) early_err++;
            if (done && done_at < 0) done_at = k;
            if (done_at < 0) begin
                if (!(cke && dqm)) pin_bad++;
            end else begin
                if (!(cke && !dqm)) pin_bad++;
            end
            case (c)
                4'b0111: ;
                4'b0010: begin pre_n++; pre_at = k; pre_addr = int'(addr); end
                4'b0001: begin
                    if (ref_n == 0) first_ref = k;
                    else if (k - last_ref != at_least(int'(v.trc), 2)) gap_bad++;
                    last_ref = k;
                    ref_n++;
                end
                4'b0000: begin mrs_n++; mrs_at = k; mrs_addr = int'(addr); mrs_ba = int'(ba); end
                default: pin_bad++;
            endcase
            if (done_at >= 0 && k >= done_at + 3) break;
            @(negedge clk);
        end
        if (do_check) begin
            p_exp = at_least(int'(v.w), 1);
            t_exp = at_least(int'(v.trp), 2);
            c_exp = at_least(int'(v.trc), 2);
            r_exp = at_least(int'(v.refs), 2);
            chk("R2", "precharge cycle", pre_at, p_exp);
            chk("R2", "precharge count", pre_n, 1);
            chk("R2", "precharge addr", pre_addr, 12'h400);
            chk("R3", "first refresh cycle", first_ref, p_exp + t_exp);
            chk("R4", "refresh count", ref_n, r_exp);
            chk("R4", "refresh spacing errors", gap_bad, 0);
            chk("R4", "mode set cycle", mrs_at, p_exp + t_exp + r_exp * c_exp);
            chk("R5", "mode set count", mrs_n, 1);
            chk("R5", "mode set bank", mrs_ba, 0);
            chk("R6", "mode word", mrs_addr, int'(v.exp_word));
            chk("R7", "lat_err", int'(lat_err), int'(v.exp_err));
            chk("R7", "lat_err before mode set", early_err, 0);
            chk("R8", "done cycle", done_at, mrs_at + 3);
            chk("R1", "pin/NOP violations", pin_bad, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // reset state, R1 R7 R8
        apply(VECS[0]);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset command pins", int'({cs_n, ras_n, cas_n, we_n}), 4'b0111);
        chk("R1", "reset cke/dqm", int'({cke, dqm}), 2'b11);
        chk("R8", "reset done", int'(done), 0);
        chk("R7", "reset lat_err", int'(lat_err), 0);

        for (int i = 0; i < NVEC; i++)
            run_vec(VECS[i], 2000, 1'b1);

        // R7 R8 R1: sticky flags long after completion
        run_vec(VECS[2], 2000, 1'b1);
        repeat (20) @(negedge clk);
        chk("R7", "lat_err held", int'(lat_err), 1);
        chk("R8", "done held", int'(done), 1);
        chk("R8", "NOP after done", int'({cs_n, ras_n, cas_n, we_n}), 4'b0111);
        chk("R1", "dqm low after done", int'(dqm), 0);

        // R2: reset in the middle of the refresh phase restarts the sequence; R7 flag cleared
        run_vec(VECS[4], 230, 1'b0);
        run_vec(VECS[0], 2000, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule